// File: doc/BRIEF.md
# Legacy Memory Window Decoder

This block sits inside a host bridge and decides where each access into the low legacy memory area should go. It holds a small set of configuration bytes, which firmware programs through a byte-wide write port. From those bytes it forms read and write enables for thirteen attribute regions, and it forms the view of the 128 KiB SMRAM window. The thirteen regions are one 64 KiB BIOS area and twelve 16 KiB expansion blocks.

For every incoming access, the block looks at the address, the direction and the SMM indicator. It then raises one routing output: read from DRAM, write to DRAM, or forward to PCI. Accesses outside the legacy area raise no output, so the surrounding fabric handles them. Configuration writes take effect on the clock edge that captures them, and every later access is routed by the new settings.

Top module: `legacy_window_decoder`

## Requirements
- R1: After reset, all attribute bytes hold 0x00 and the SMRAM control byte holds 0x02, so every access in 0xA0000..0xFFFFF is forwarded to PCI.
- R2: A write to an offset from 0x59 to 0x5F, or to offset 0x72, is captured on the clock edge that samples it. Accesses from the following cycle onward are routed by the new value.
- R3: A write to any other offset changes no routing decision.
- R4: Region 0 covers 0xF0000..0xFFFFF and takes its field from byte 0x59. Region i, for i from 1 to 12, covers 16 KiB starting at 0xC0000 + (i-1)*0x4000 and takes its field from byte 0x59 + (i+1)/2. Region 0 and the odd regions use the high nibble. The even regions use the low nibble.
- R5: A read in an attribute region goes to DRAM (dram_rd) when bit 0 of its nibble is set. Otherwise it is forwarded to PCI.
- R6: A write in an attribute region goes to DRAM (dram_wr) when bit 1 of its nibble is set. Otherwise it is forwarded to PCI, and dram_wr stays low.
- R7: A non-SMM access in 0xA0000..0xBFFFF goes to DRAM when bit 6 (open) of byte 0x72 is set. Otherwise it goes to PCI.
- R8: An SMM access in 0xA0000..0xBFFFF goes to DRAM when bit 3 (global enable) of byte 0x72 is set. Otherwise it is routed as a non-SMM access would be.
- R9: An address inside 0xA0000..0xFFFFF raises exactly one of dram_rd, dram_wr and pci_fwd. Any other address, including one with upper bits set, raises none of them.
- R10: Bits 2 and 3 of each attribute nibble have no effect on routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_wr_ofs | input | 8 | Configuration byte offset |
| cfg_wr_data | input | 8 | Configuration byte value |
| acc_addr | input | ADDR_W (32) | Address of the current memory access |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| acc_smm | input | 1 | Access is issued in system management mode |
| dram_rd | output | 1 | Serve this read from DRAM |
| dram_wr | output | 1 | Commit this write to DRAM |
| pci_fwd | output | 1 | Forward this access to PCI |

## Verification
The routing of the full legacy area is tested with several attribute patterns, and the expected result for each is computed from the address arithmetic:
- Read-only, write-only and read-write patterns on every byte separate the read path from the write path.
- A pattern that differs from byte to byte tests both halves of each byte. This catches a wrong nibble or a wrong byte for any region.
- A pattern that sets only bits 2 and 3 shows that those bits have no effect.

All 256 SMRAM control values are applied with both SMM states and both directions. This separates the open bit from the global enable. Writes to neighbouring offsets, and addresses just outside the area or with high bits set, show that the decoder ignores them.

// File: rtl/lw_pkg.sv
package lw_pkg;

    // Configuration layout
    localparam int          ATTR_BYTES = 7;
    localparam logic [7:0]  ATTR_OFS   = 8'h59;
    localparam logic [7:0]  SMRAM_OFS  = 8'h72;
    localparam logic [7:0]  SMRAM_RST  = 8'h02;
    localparam int          OPEN_BIT   = 6;
    localparam int          GEN_BIT    = 3;

    // Region set: one BIOS region plus the expansion blocks
    localparam int N_EXP  = 12;
    localparam int N_REG  = N_EXP + 1;
    localparam int REG_W  = $clog2(N_REG);

    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_DRAM = 2'd1,
        DST_PCI  = 2'd2
    } dest_e;

    typedef struct packed {
        logic we;
        logic re;
    } attr_t;

    typedef struct packed {
        attr_t hi;
        attr_t lo;
    } attr_pair_t;

    typedef struct packed {
        logic             in_attr;
        logic             in_smram;
        logic [REG_W-1:0] region;
    } win_t;

    // Byte index (relative to ATTR_OFS) that holds a region's field
    function automatic int byte_of(input int r);
        return (r + 1) / 2;
    endfunction

    // Region 0 and odd regions sit in the upper nibble
    function automatic bit uses_high(input int r);
        return (r == 0) || ((r % 2) == 1);
    endfunction

endpackage

// File: rtl/lw_cfg_regs.sv
module lw_cfg_regs
    import lw_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [7:0]                       wr_ofs,
    input  logic [7:0]                       wr_data,
    output attr_pair_t [ATTR_BYTES-1:0]      attr_q,
    output logic                             smram_open,
    output logic                             smram_gen
);

    logic [7:0] smram_q;

    genvar b;
    generate
        for (b = 0; b < ATTR_BYTES; b++) begin : g_attr
            localparam logic [7:0] MY_OFS = ATTR_OFS + 8'(b);
            always_ff @(posedge clk) begin
                if (rst) begin
                    attr_q[b] <= '0;
                end else if (wr_en && (wr_ofs == MY_OFS)) begin
                    attr_q[b].hi <= '{we: wr_data[5], re: wr_data[4]};
                    attr_q[b].lo <= '{we: wr_data[1], re: wr_data[0]};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            smram_q <= SMRAM_RST;
        end else if (wr_en && (wr_ofs == SMRAM_OFS)) begin
            smram_q <= wr_data;
        end
    end

    assign smram_open = smram_q[OPEN_BIT];
    assign smram_gen  = smram_q[GEN_BIT];

    // Offset range claimed by this block (for the checks below)
    logic ofs_claimed;
    assign ofs_claimed = (wr_ofs >= ATTR_OFS && wr_ofs <= ATTR_OFS + 8'(ATTR_BYTES - 1))
                       || (wr_ofs == SMRAM_OFS);

    // R1: first cycle out of reset shows the reset image
    p_reset_image_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (attr_q == '0 && smram_q == SMRAM_RST));

    // R3: writes elsewhere leave all state untouched
    p_foreign_ofs_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ofs_claimed) |=> ($stable(attr_q) && $stable(smram_q)));

    // R2: SMRAM control takes the written byte on the next cycle
    p_smram_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ofs == SMRAM_OFS) |=> (smram_q == $past(wr_data)));

endmodule

// File: rtl/lw_region_map.sv
module lw_region_map
    import lw_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] BIOS_BASE  = 'hF0000,
    parameter int                BIOS_LOG2  = 16,
    parameter logic [ADDR_W-1:0] EXP_BASE   = 'hC0000,
    parameter int                EXP_LOG2   = 14,
    parameter logic [ADDR_W-1:0] SMRAM_BASE = 'hA0000,
    parameter int                SMRAM_LOG2 = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    output win_t              win
);

    localparam logic [ADDR_W-1:0] BIOS_LAST  = BIOS_BASE  + ((ADDR_W'(1) << BIOS_LOG2)  - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] SMRAM_LAST = SMRAM_BASE + ((ADDR_W'(1) << SMRAM_LOG2) - ADDR_W'(1));

    logic [N_REG-1:0] hit;
    logic             smram_hit;

    genvar r;
    generate
        for (r = 0; r < N_REG; r++) begin : g_reg
            if (r == 0) begin : g_bios
                assign hit[r] = (addr >= BIOS_BASE) && (addr <= BIOS_LAST);
            end else begin : g_exp
                localparam logic [ADDR_W-1:0] LO =
                    EXP_BASE + (ADDR_W'(r - 1) << EXP_LOG2);
                localparam logic [ADDR_W-1:0] HI =
                    LO + ((ADDR_W'(1) << EXP_LOG2) - ADDR_W'(1));
                assign hit[r] = (addr >= LO) && (addr <= HI);
            end
        end
    endgenerate

    assign smram_hit = (addr >= SMRAM_BASE) && (addr <= SMRAM_LAST);

    logic [REG_W-1:0] region_idx;
    always_comb begin
        region_idx = '0;
        for (int i = 0; i < N_REG; i++) begin
            if (hit[i]) region_idx = REG_W'(i);
        end
    end

    assign win.in_attr  = |hit;
    assign win.in_smram = smram_hit;
    assign win.region   = region_idx;

    // R4: regions never overlap each other or the SMRAM window
    p_disjoint_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit, smram_hit}));

endmodule

// File: rtl/lw_attr_select.sv
module lw_attr_select
    import lw_pkg::*;
(
    input  attr_pair_t [ATTR_BYTES-1:0] attr_q,
    output attr_t      [N_REG-1:0]      region_attr
);

    genvar r;
    generate
        for (r = 0; r < N_REG; r++) begin : g_sel
            localparam int BI = byte_of(r);
            if (uses_high(r)) begin : g_hi
                assign region_attr[r] = attr_q[BI].hi;
            end else begin : g_lo
                assign region_attr[r] = attr_q[BI].lo;
            end
        end
    endgenerate

endmodule

// File: rtl/lw_route.sv
module lw_route
    import lw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  win_t                 win,
    input  attr_t [N_REG-1:0]    region_attr,
    input  logic                 smram_open,
    input  logic                 smram_gen,
    input  logic                 acc_write,
    input  logic                 acc_smm,
    output logic                 dram_rd,
    output logic                 dram_wr,
    output logic                 pci_fwd
);

    attr_t sel;
    dest_e dest;

    always_comb begin
        sel = '0;
        for (int r = 0; r < N_REG; r++) begin
            if (win.region == REG_W'(r)) sel = region_attr[r];
        end
    end

    always_comb begin
        dest = DST_NONE;
        if (win.in_smram) begin
            if (acc_smm && smram_gen)  dest = DST_DRAM;
            else if (smram_open)       dest = DST_DRAM;
            else                       dest = DST_PCI;
        end else if (win.in_attr) begin
            if (acc_write ? sel.we : sel.re) dest = DST_DRAM;
            else                             dest = DST_PCI;
        end
    end

    assign dram_rd = (dest == DST_DRAM) && !acc_write;
    assign dram_wr = (dest == DST_DRAM) &&  acc_write;
    assign pci_fwd = (dest == DST_PCI);

    // R9: exactly one destination inside the legacy area, none outside
    p_one_dest_r9: assert property (@(posedge clk) disable iff (rst)
        (win.in_attr || win.in_smram) |-> ($countones({dram_rd, dram_wr, pci_fwd}) == 1));
    p_no_dest_r9: assert property (@(posedge clk) disable iff (rst)
        !(win.in_attr || win.in_smram) |-> !(dram_rd || dram_wr || pci_fwd));

    // R5 / R6: DRAM strobes follow the access direction
    p_rd_dir_r5: assert property (@(posedge clk) disable iff (rst)
        dram_rd |-> !acc_write);
    p_wr_dir_r6: assert property (@(posedge clk) disable iff (rst)
        dram_wr |-> acc_write);

    // R7: closed SMRAM is invisible to non-SMM accesses
    p_closed_r7: assert property (@(posedge clk) disable iff (rst)
        (win.in_smram && !acc_smm && !smram_open) |-> pci_fwd);

    // R8: globally enabled SMRAM always serves SMM from DRAM
    p_smm_dram_r8: assert property (@(posedge clk) disable iff (rst)
        (win.in_smram && acc_smm && smram_gen) |-> !pci_fwd);

endmodule

// File: rtl/legacy_window_decoder.sv
module legacy_window_decoder
    import lw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [7:0]        cfg_wr_ofs,
    input  logic [7:0]        cfg_wr_data,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_smm,
    output logic              dram_rd,
    output logic              dram_wr,
    output logic              pci_fwd
);

    attr_pair_t [ATTR_BYTES-1:0] attr_q;
    attr_t      [N_REG-1:0]      region_attr;
    logic                        smram_open;
    logic                        smram_gen;
    win_t                        win;

    lw_cfg_regs u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cfg_wr_en),
        .wr_ofs     (cfg_wr_ofs),
        .wr_data    (cfg_wr_data),
        .attr_q     (attr_q),
        .smram_open (smram_open),
        .smram_gen  (smram_gen)
    );

    lw_attr_select u_sel (
        .attr_q      (attr_q),
        .region_attr (region_attr)
    );

    lw_region_map #(
        .ADDR_W (ADDR_W)
    ) u_map (
        .clk  (clk),
        .rst  (rst),
        .addr (acc_addr),
        .win  (win)
    );

    lw_route u_route (
        .clk         (clk),
        .rst         (rst),
        .win         (win),
        .region_attr (region_attr),
        .smram_open  (smram_open),
        .smram_gen   (smram_gen),
        .acc_write   (acc_write),
        .acc_smm     (acc_smm),
        .dram_rd     (dram_rd),
        .dram_wr     (dram_wr),
        .pci_fwd     (pci_fwd)
    );

endmodule

// File: tb/legacy_window_decoder_tb.sv
module legacy_window_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_ofs = 8'h00;
    logic [7:0]  cfg_wr_data = 8'h00;
    logic [31:0] acc_addr = 32'h0;
    logic        acc_write = 1'b0;
    logic        acc_smm = 1'b0;
    logic        dram_rd, dram_wr, pci_fwd;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] m_attr [7];
    logic [7:0] m_smram;

    always #4 clk = ~clk;

    legacy_window_decoder #(.ADDR_W(32)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_ofs(cfg_wr_ofs), .cfg_wr_data(cfg_wr_data),
        .acc_addr(acc_addr), .acc_write(acc_write), .acc_smm(acc_smm),
        .dram_rd(dram_rd), .dram_wr(dram_wr), .pci_fwd(pci_fwd)
    );

    // Expected {dram_rd, dram_wr, pci_fwd} from the requirements
    function automatic logic [2:0] expect_route(logic [31:0] a, bit w, bit smm);
        int  r;
        bit  en;
        logic [7:0] by;
        logic [3:0] nib;
        if (a >= 32'hA0000 && a <= 32'hBFFFF) begin
            en = (smm && m_smram[3]) ? 1'b1 : m_smram[6];
        end else if (a >= 32'hC0000 && a <= 32'hFFFFF) begin
            r   = (a >= 32'hF0000) ? 0 : 1 + int'((a - 32'hC0000) >> 14);
            by  = m_attr[(r + 1) / 2];
            nib = (r == 0 || (r % 2) == 1) ? by[7:4] : by[3:0];
            en  = w ? nib[1] : nib[0];
        end else begin
            return 3'b000;
        end
        if (!en) return 3'b001;
        return w ? 3'b010 : 3'b100;
    endfunction

    function automatic string kind_tag(logic [31:0] a, bit w, bit smm);
        if (a >= 32'hA0000 && a <= 32'hBFFFF) return smm ? "R8" : "R7";
        if (a >= 32'hC0000 && a <= 32'hFFFFF) return w ? "R6" : "R5";
        return "R9";
    endfunction

    task automatic cfg_write(input logic [7:0] ofs, input logic [7:0] val, input bit model_it);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_ofs  = ofs;
        cfg_wr_data = val;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
        if (model_it) begin
            if (ofs >= 8'h59 && ofs <= 8'h5F) m_attr[ofs - 8'h59] = val;
            else if (ofs == 8'h72)            m_smram = val;
        end
    endtask

    task automatic probe(input string scen, input logic [31:0] a, input bit w, input bit smm);
        logic [2:0] exp_v, got;
        @(negedge clk);
        acc_addr  = a;
        acc_write = w;
        acc_smm   = smm;
        #1;
        got   = {dram_rd, dram_wr, pci_fwd};
        exp_v = expect_route(a, w, smm);
        checks++;
        if (got !== exp_v) begin
            errors++;
            $display("FAIL %s/%s addr=%h wr=%0b smm=%0b actual=%b expected=%b",
                     scen, kind_tag(a, w, smm), a, w, smm, got, exp_v);
        end
    endtask

    task automatic sweep(input string scen);
        for (int off = 0; off < 32'h60000; off += 32'h800) begin
            for (int k = 0; k < 4; k++) begin
                probe(scen, 32'hA0000 + off,          k[0], k[1]);
                probe(scen, 32'hA0000 + off + 32'h7FF, k[0], k[1]);
            end
        end
    endtask

    task automatic fill_attr(input logic [7:0] v);
        for (int b = 0; b < 7; b++) cfg_write(8'h59 + 8'(b), v, 1'b1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        for (int b = 0; b < 7; b++) m_attr[b] = 8'h00;
        m_smram = 8'h02;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset image, everything to PCI
        sweep("R1");

        // R3: neighbouring and unrelated offsets are ignored
        cfg_write(8'h58, 8'hFF, 1'b0);
        cfg_write(8'h60, 8'hFF, 1'b0);
        cfg_write(8'h71, 8'hFF, 1'b0);
        cfg_write(8'h73, 8'hFF, 1'b0);
        cfg_write(8'hD9, 8'hFF, 1'b0);
        cfg_write(8'h19, 8'hFF, 1'b0);
        sweep("R3");

        // R2/R5: read-only in both nibbles
        fill_attr(8'h11);
        sweep("R2");
        // R6: write-only
        fill_attr(8'h22);
        sweep("R6");
        // read-write everywhere
        fill_attr(8'h33);
        sweep("R5");
        // R10: only the non-attribute bits set
        fill_attr(8'hCC);
        sweep("R10");
        // R4: nibble halves differ, per-byte distinct values
        fill_attr(8'h12);
        sweep("R4");
        fill_attr(8'h21);
        sweep("R4");
        for (int b = 0; b < 7; b++)
            cfg_write(8'h59 + 8'(b), 8'((b * 8'h47) + 8'h1D), 1'b1);
        sweep("R4");

        // R7/R8: every SMRAM control value, both window edges
        for (int v = 0; v < 256; v++) begin
            cfg_write(8'h72, 8'(v), 1'b1);
            for (int k = 0; k < 4; k++) begin
                probe("R2", 32'hA0000, k[0], k[1]);
                probe("R2", 32'hBFFFF, k[0], k[1]);
            end
        end

        // R9: addresses outside the legacy area
        fill_attr(8'h33);
        cfg_write(8'h72, 8'h48, 1'b1);
        for (int k = 0; k < 4; k++) begin
            probe("R9", 32'h0009FFFF, k[0], k[1]);
            probe("R9", 32'h00000000, k[0], k[1]);
            probe("R9", 32'h00100000, k[0], k[1]);
            probe("R9", 32'h100A0000, k[0], k[1]);
            probe("R9", 32'h100F0000, k[0], k[1]);
            probe("R9", 32'hFFFFFFFF, k[0], k[1]);
        end

        // R1: reset in mid-run restores the reset image
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int b = 0; b < 7; b++) m_attr[b] = 8'h00;
        m_smram = 8'h02;
        sweep("R1");

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule